// File: doc/BRIEF.md
# Store Buffer with Load Bypass

This block sits between one processor request port and a single-ported memory. Stores are parked in a small first-in first-out queue and written to memory in the background, one at a time. A later load does not wait behind them. If its address matches a queued store, the newest such store supplies the data and memory is not touched. Otherwise the load is sent to memory ahead of the queued stores.

Two requests act as ordering points: an atomic swap and a fence. A swap exchanges a register value with a memory word. It waits until every queued store has been written. It then reads the old word and writes the new one, with no other memory access between the two. A fence simply waits for the queue to drain and for memory to go idle, and then it is acknowledged.

Requests use a valid/ready channel. Responses come back as a one-cycle pulse. Opcodes: 0 load, 1 store, 2 swap, 3 fence. The memory port allows one access at a time. Each accepted access, read or write, is answered by one response pulse.

Top module: `store_buffer`

## Requirements
- R1: After reset, `rsp_valid` and `mem_req_valid` are low while no request is presented.
- R2: A store (op 1) is accepted while fewer than DEPTH (4) entries are queued. With DEPTH entries queued, `req_ready` stays low for a store.
- R3: Queued stores reach memory in exactly the order they were accepted, with their own address and data.
- R4: A load (op 0) that matches no queued entry is issued to memory before any queued store is drained. The memory port gives a waiting load priority over draining.
- R5: A load that matches one or more queued entries returns the data of the most recently accepted matching store. `rsp_valid` rises in the cycle after acceptance, and no memory read takes place.
- R6: A swap (op 2) is accepted only when the queue is empty. Its memory write immediately follows its memory read at the same address. It returns the old value, and the new value becomes visible.
- R7: A fence (op 3) is accepted only when the queue is empty and no memory access is in flight. `rsp_valid` rises in the next cycle with `rsp_rdata` equal to zero.
- R8: At most one memory access is outstanding. After a memory handshake, `mem_req_valid` is low in the following cycle.
- R9: A load that misses the queue returns the word memory holds, one cycle after the memory response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 swap, 3 fence |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store or swap data |
| rsp_valid | output | 1 | Response pulse for load, swap, fence |
| rsp_rdata | output | DW | Response data |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | AW | Memory address |
| mem_req_wdata | output | DW | Memory write data |
| mem_rsp_valid | input | 1 | Memory access finished |
| mem_rsp_rdata | input | DW | Read data from memory |

## Verification
The bench stalls memory so that the queue fills. It then probes the fifth store, which a buffer with an off-by-one limit would accept and overwrite. While stores are still parked, it sends a load to a different address; a port that drains first would record a write before the read. It places two stores to one address and then loads that address, so picking the oldest match, or fetching stale memory, shows up as wrong data or an extra read. Swaps and fences are issued behind parked stores, and a long pseudo-random mix with a stalling memory compares every response and every memory write against a program-order model. A swap that skipped draining returns a stale old value, and a fence acknowledged too early finds writes still missing.

// File: rtl/store_buffer.sv
module store_buffer #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_SW = 2'd2, OP_FN = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_DRAIN, S_SWRD, S_SWISS, S_SWWR} state_t;
  state_t state;

  logic [AW-1:0] q_addr [DEPTH];
  logic [DW-1:0] q_data [DEPTH];
  logic [PW-1:0] head, tail, idx;
  logic [CW-1:0] count;
  logic [AW-1:0] sw_addr;
  logic [DW-1:0] sw_data, sw_old;
  logic          hit;
  logic [DW-1:0] hit_data;

  always_comb begin
    hit = 1'b0;
    hit_data = '0;
    idx = head;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PW'(k);
      if (CW'(k) < count && q_addr[idx] == req_addr) begin
        hit = 1'b1;
        hit_data = q_data[idx];
      end
    end
  end

  wire idle  = state == S_IDLE;
  wire empty = count == '0;
  wire full  = count == CW'(DEPTH);
  wire is_ld = req_op == OP_LD;
  wire is_st = req_op == OP_ST;
  wire is_sw = req_op == OP_SW;
  wire is_fn = req_op == OP_FN;

  wire ld_miss_go = idle && req_valid && is_ld && !hit;
  wire sw_go      = idle && req_valid && is_sw && empty;
  wire drain_go   = idle && !empty && !ld_miss_go;

  assign mem_req_valid = (state == S_SWISS) || ld_miss_go || sw_go || drain_go;
  assign mem_req_we    = (state == S_SWISS) || drain_go;
  assign mem_req_addr  = (state == S_SWISS) ? sw_addr : drain_go ? q_addr[head] : req_addr;
  assign mem_req_wdata = (state == S_SWISS) ? sw_data : q_data[head];
  wire mem_fire = mem_req_valid && mem_req_ready;

  always_comb begin
    unique case (req_op)
      OP_LD:   req_ready = (idle || state == S_DRAIN) && (hit || (idle && mem_req_ready));
      OP_ST:   req_ready = (idle || state == S_DRAIN) && !full;
      OP_SW:   req_ready = idle && empty && mem_req_ready;
      default: req_ready = idle && empty;
    endcase
  end

  wire acc  = req_valid && req_ready;
  wire push = acc && is_st;
  wire pop  = (state == S_DRAIN) && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[tail] <= req_addr;
      q_data[tail] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      head      <= '0;
      tail      <= '0;
      count     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      sw_addr   <= '0;
      sw_data   <= '0;
      sw_old    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
      count <= count + CW'(push) - CW'(pop);
      if (acc && is_ld && hit) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= hit_data;
      end
      if (acc && is_fn) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= '0;
      end
      unique case (state)
        S_IDLE: if (mem_fire) begin
          if (ld_miss_go) state <= S_LOAD;
          else if (sw_go) begin
            state   <= S_SWRD;
            sw_addr <= req_addr;
            sw_data <= req_wdata;
          end else state <= S_DRAIN;
        end
        S_LOAD: if (mem_rsp_valid) begin
          state     <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= mem_rsp_rdata;
        end
        S_DRAIN: if (mem_rsp_valid) state <= S_IDLE;
        S_SWRD: if (mem_rsp_valid) begin
          state  <= S_SWISS;
          sw_old <= mem_rsp_rdata;
        end
        S_SWISS: if (mem_fire) state <= S_SWWR;
        S_SWWR: if (mem_rsp_valid) begin
          state     <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= sw_old;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_full_refuse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_st && full) |-> !req_ready);
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_hit_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_ld && hit) |-> !(mem_fire && !mem_req_we));
  assert_swap_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_fire && !mem_req_we && req_valid && is_sw) |-> empty);
  assert_swap_write_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SWRD && mem_rsp_valid) |=> (mem_req_valid && mem_req_we && mem_req_addr == sw_addr));
  assert_fence_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && is_fn) |=> (rsp_valid && rsp_rdata == '0));
  assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fire |=> !mem_req_valid);
endmodule

// File: tb/store_buffer_bench.sv
module store_buffer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_req_valid, mem_req_we, mem_req_ready;
  logic [7:0]  mem_req_addr;
  logic [15:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [15:0] mem_rsp_rdata;

  logic mready_man = 1'b1;
  logic rand_mode = 1'b0;
  logic rnd_bit = 1'b1;
  assign mem_req_ready = rand_mode ? rnd_bit : mready_man;

  store_buffer u_store_buffer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int checks = 0, errors = 0;
  int reads_hs = 0, writes_hs = 0, writes_at_read = 0;
  int refmem [256];
  logic [15:0] mem [256];
  int exp_writes [$];
  bit in_swap = 0, swap_pend = 0;
  int swap_addr = 0;
  int lfsr = 32'h1234_5677;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    rnd_bit = lfsr[3] | lfsr[7];
  end

  always @(posedge clk) begin
    if (!rst_n) mem_rsp_valid <= 1'b0;
    else begin
      mem_rsp_valid <= mem_req_valid && mem_req_ready;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_rdata <= mem[mem_req_addr];
        if (mem_req_we) begin
          int e;
          mem[mem_req_addr] <= mem_req_wdata;
          writes_hs++;
          e = (exp_writes.size() > 0) ? exp_writes.pop_front() : -1;
          chk(e == {8'd0, mem_req_addr, mem_req_wdata}, "R3 write order", {8'd0, mem_req_addr, mem_req_wdata}, e);
          if (swap_pend) chk(int'(mem_req_addr) == swap_addr, "R6 swap write address", mem_req_addr, swap_addr);
          swap_pend = 0;
        end else begin
          if (swap_pend) chk(0, "R6 swap access between read and write", mem_req_addr, swap_addr);
          reads_hs++;
          writes_at_read = writes_hs;
          if (in_swap) begin swap_pend = 1; swap_addr = mem_req_addr; end
        end
      end
    end
  end

  // returns expected response; waits for acceptance
  task automatic issue(input logic [1:0] op, input int a, input int d, output int exp);
    req_valid = 1'b1; req_op = op; req_addr = a[7:0]; req_wdata = d[15:0];
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    exp = 0;
    case (op)
      2'd0: exp = refmem[a];
      2'd1: begin refmem[a] = d; exp_writes.push_back({8'd0, a[7:0], d[15:0]}); end
      2'd2: begin exp = refmem[a]; refmem[a] = d; exp_writes.push_back({8'd0, a[7:0], d[15:0]}); end
      default: exp = 0;
    endcase
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(input string req, input int exp, output int lat);
    lat = 0;
    while (!rsp_valid && lat < 200) begin @(negedge clk); lat++; end
    chk(rsp_valid && rsp_rdata == exp[15:0], req, rsp_rdata, exp);
  endtask

  task automatic store(input int a, input int d);
    int e;
    issue(2'd1, a, d, e);
  endtask

  task automatic load(input string req, input int a, output int lat);
    int e;
    issue(2'd0, a, 0, e);
    wait_rsp(req, e, lat);
  endtask

  task automatic swap(input string req, input int a, input int d);
    int e, lat;
    in_swap = 1;
    issue(2'd2, a, d, e);
    wait_rsp(req, e, lat);
    in_swap = 0;
  endtask

  task automatic fence(input string req, output int lat);
    int e;
    issue(2'd3, 0, 0, e);
    wait_rsp(req, 0, lat);
    chk(exp_writes.size() == 0, "R7 all stores written at fence ack", exp_writes.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat, r0, w0;
    for (int i = 0; i < 256; i++) begin mem[i] = 16'(i * 3 + 1); refmem[i] = i * 3 + 1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && !mem_req_valid, "R1 reset idle", {rsp_valid, mem_req_valid}, 0);

    // basic store, hit, fence, miss
    store(10, 16'h0111);
    load("R5 hit or miss after store", 10, lat);
    fence("R7 fence", lat);
    r0 = reads_hs;
    load("R9 miss data", 10, lat);
    chk(reads_hs == r0 + 1, "R9 miss goes to memory", reads_hs - r0, 1);
    load("R9 miss untouched word", 40, lat);

    // full buffer
    mready_man = 1'b0;
    for (int i = 1; i <= 4; i++) store(i, 16'h0a00 + i);
    req_valid = 1'b1; req_op = 2'd1; req_addr = 8'd5; req_wdata = 16'h0bad;
    #1;
    chk(!req_ready, "R2 fifth store refused", req_ready, 0);
    req_valid = 1'b0;
    r0 = reads_hs;
    load("R5 hit while stalled", 3, lat);
    chk(lat == 0, "R5 hit latency one cycle", lat, 0);
    chk(reads_hs == r0, "R5 hit makes no memory read", reads_hs - r0, 0);
    // relaxation: miss overtakes parked stores
    w0 = writes_hs;
    mready_man = 1'b1;
    load("R9 overtaking load data", 20, lat);
    chk(writes_at_read == w0, "R4 load read before parked stores", writes_at_read, w0);
    fence("R7 fence after drain", lat);

    // youngest match
    mready_man = 1'b0;
    store(7, 16'h000a);
    store(7, 16'h000b);
    store(8, 16'h000c);
    r0 = reads_hs;
    load("R5 youngest match", 7, lat);
    chk(reads_hs == r0, "R5 youngest hit no read", reads_hs - r0, 0);
    mready_man = 1'b1;
    fence("R7 fence drains three", lat);

    // swap behind a parked store
    mready_man = 1'b0;
    store(30, 16'h0055);
    mready_man = 1'b1;
    swap("R6 swap old value after drain", 30, 16'h0099);
    load("R6 swap new value visible", 30, lat);
    swap("R6 swap fresh word", 50, 16'h1234);
    load("R6 swap fresh new value", 50, lat);

    // fence on empty buffer answers next cycle
    fence("R7 fence empty", lat);
    chk(lat == 0, "R7 fence latency", lat, 0);

    // random mix
    rand_mode = 1'b1;
    for (int n = 0; n < 300; n++) begin
      int a, op;
      a = (lfsr >>> 5) & 7;
      op = (lfsr >>> 9) & 15;
      if (op < 7) store(a, (lfsr >>> 12) & 16'hffff);
      else if (op < 13) load("R5 R9 mixed load", a, lat);
      else if (op < 15) swap("R6 mixed swap", a, (lfsr >>> 14) & 16'hffff);
      else fence("R7 mixed fence", lat);
    end
    rand_mode = 1'b0;
    fence("R3 final fence", lat);
    for (int i = 0; i < 8; i++)
      chk(int'(mem[i]) == refmem[i], "R3 final memory image", mem[i], refmem[i]);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule